// File: doc/BRIEF.md
# SPI Register Access Command Engine

This block is the master side of a serial link to an SPI-attached network controller whose registers are 16 bits wide. A client presents one request at a time: an 8-bit register offset, an operation code and a 16-bit argument. The engine builds a two-byte command header and drops chip select. It then shifts out the header followed by a 16-bit data phase and raises chip select again. It finishes with a one-cycle completion pulse. A read returns the register value on `rd_data`.

Two compound operations, set-bits and clear-bits, run as a read-modify-write pair of transactions that the engine sequences itself. The client therefore sees one atomic request. The serial clock comes from a divider of the system clock inside the block. The link runs in SPI mode 0. Chip select always stays high for at least one full serial clock period between transactions.

Top module: `spi_reg_engine`

## Requirements
- R1: Header byte 0 (first byte on the wire) carries the wire opcode in bits 7:6 and register offset bits 7:6 in bits 1:0. The wire opcode is 00 for a register read and 01 for a register write. Codes 10 and 11 are reserved for bulk transfers and are never issued.
- R2: Header byte 1 carries register offset bits 5:2 in bits 7:4, and bits 3:0 are zero.
- R3: Header byte 0 bits 5:2 are the lane enables: 0011 when offset bit 1 is 0 and 1100 when offset bit 1 is 1.
- R4: SPI mode 0. SCLK rests low whenever chip select is high, and MOSI only changes while SCLK is low. The header is sent byte 0 then byte 1, and the data word is sent low byte then high byte, every byte MSB first.
- R5: Each transaction holds `spi_cs_n` low for exactly 32 SCLK rising edges: 16 for the header and 16 for data. Chip select rises only after the last falling SCLK edge.
- R6: Request op 00 (read) performs one read transaction, and `rd_data` holds the register value in the cycle `done` pulses. Request op 01 (write) performs one write transaction carrying `req_wdata`.
- R7: Request op 10 (set) reads the register and then writes back old OR `req_wdata`. `rd_data` returns the old value at `done`.
- R8: Request op 11 (clear) reads the register and then writes back old AND NOT `req_wdata`. `rd_data` returns the old value at `done`.
- R9: A request is taken only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high exactly when the engine is idle, including the cycle in which `done` pulses. A request presented while the engine is busy has no effect.
- R10: `busy` rises in the cycle after a request is taken and stays high until the cycle in which `done` pulses, when it is low. `done` is high for one cycle per request.
- R11: Every SCLK half-period lasts `HALF_DIV` system clocks, and the first rising edge comes `HALF_DIV` clocks after chip select falls. Chip select stays high for at least 2*`HALF_DIV` clocks between any two transactions.
- R12: Out of reset `spi_cs_n` is 1, `spi_sclk` is 0, `busy` and `done` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request will be taken |
| req_op | input | 2 | 00 read, 01 write, 10 set bits, 11 clear bits |
| req_addr | input | 8 | Register byte offset |
| req_wdata | input | 16 | Write data, or bit mask for set and clear |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Value read (old value for set and clear) |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the controller |
| spi_miso | input | 1 | Serial data from the controller |

## Verification
Two events can fall in the same cycle: the completion pulse of one request and the acceptance of the next. The bench holds a second request on the input while the first is still running. The request must then be taken exactly in the `done` cycle. Its first transaction must still respect the chip-select gap, and the behavioural serial device must see its header in order. The opposite overlap is a request raised mid-transfer, which must not be taken. The bench judges this by reading the targeted register back through the engine and finding it unchanged.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  localparam int HDR_BITS   = 16;
  localparam int WORD_BITS  = 16;
  localparam int FRAME_BITS = HDR_BITS + WORD_BITS;

  typedef enum logic [1:0] {
    REQ_READ  = 2'b00,
    REQ_WRITE = 2'b01,
    REQ_SET   = 2'b10,
    REQ_CLEAR = 2'b11
  } req_op_e;

  typedef enum logic [1:0] {
    WIRE_RD_REG  = 2'b00,
    WIRE_WR_REG  = 2'b01,
    WIRE_RD_BULK = 2'b10,
    WIRE_WR_BULK = 2'b11
  } wire_op_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_LAUNCH,
    S_XFER,
    S_GAP
  } seq_state_e;

  // Two lanes of the 32-bit word, picked by offset bit 1.
  function automatic logic [3:0] lane_sel(input logic [7:0] offs);
    return offs[1] ? 4'b1100 : 4'b0011;
  endfunction

  function automatic logic [HDR_BITS-1:0] make_header(input wire_op_e op,
                                                      input logic [7:0] offs);
    return {op, lane_sel(offs), offs[7:6], offs[5:2], 4'b0000};
  endfunction

  function automatic logic [WORD_BITS-1:0] merge_bits(input req_op_e op,
                                                      input logic [WORD_BITS-1:0] old,
                                                      input logic [WORD_BITS-1:0] mask);
    case (op)
      REQ_SET:   return old | mask;
      REQ_CLEAR: return old & ~mask;
      default:   return mask;
    endcase
  endfunction

  // Data travels low byte first.
  function automatic logic [FRAME_BITS-1:0] pack_frame(input logic [HDR_BITS-1:0] hdr,
                                                       input logic [WORD_BITS-1:0] dat);
    return {hdr, dat[7:0], dat[15:8]};
  endfunction

  function automatic logic [WORD_BITS-1:0] unpack_word(input logic [WORD_BITS-1:0] rx);
    return {rx[7:0], rx[15:8]};
  endfunction

endpackage

// File: rtl/spi_reg_clkdiv.sv
module spi_reg_clkdiv #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  generate
    if (HALF_DIV <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_count
      localparam int CW = $clog2(HALF_DIV);
      logic [CW-1:0] cnt_q;
      logic          wrap;

      assign wrap = (cnt_q == CW'(HALF_DIV - 1));
      assign tick = run && wrap;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (!run || wrap) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  endgenerate

endmodule

// File: rtl/spi_reg_shifter.sv
module spi_reg_shifter #(
  parameter int FRAME_BITS = 32,
  parameter int RX_BITS    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  tick,
  input  logic [FRAME_BITS-1:0] tx_frame,
  input  logic                  miso,
  output logic                  cs_n,
  output logic                  sclk,
  output logic                  mosi,
  output logic [RX_BITS-1:0]    rx_word,
  output logic                  active,
  output logic                  rise_evt,
  output logic                  finish
);

  localparam int BW = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] sreg_q;
  logic [BW-1:0]         bit_q;
  logic                  last_bit;
  logic                  fall_evt;

  assign last_bit = (bit_q == BW'(FRAME_BITS - 1));
  assign rise_evt = active && tick && !sclk;
  assign fall_evt = active && tick && sclk;
  assign mosi     = active ? sreg_q[FRAME_BITS-1] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cs_n    <= 1'b1;
      sclk    <= 1'b0;
      sreg_q  <= '0;
      bit_q   <= '0;
      rx_word <= '0;
      finish  <= 1'b0;
    end else begin
      finish <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          cs_n   <= 1'b0;
          sclk   <= 1'b0;
          sreg_q <= tx_frame;
          bit_q  <= '0;
        end
      end else if (rise_evt) begin
        sclk    <= 1'b1;
        rx_word <= {rx_word[RX_BITS-2:0], miso};
      end else if (fall_evt) begin
        sclk <= 1'b0;
        if (last_bit) begin
          active <= 1'b0;
          cs_n   <= 1'b1;
          finish <= 1'b1;
        end else begin
          sreg_q <= {sreg_q[FRAME_BITS-2:0], 1'b0};
          bit_q  <= bit_q + BW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/spi_reg_seq.sv
module spi_reg_seq
  import spi_reg_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [1:0]            req_op,
  input  logic [7:0]            req_addr,
  input  logic [WORD_BITS-1:0]  req_wdata,
  input  logic                  shift_finish,
  input  logic [WORD_BITS-1:0]  rx_word,
  output logic                  req_ready,
  output logic                  busy,
  output logic                  done,
  output logic [WORD_BITS-1:0]  rd_data,
  output logic                  start,
  output logic [FRAME_BITS-1:0] tx_frame
);

  localparam int GAP_CYC = 2 * HALF_DIV;
  localparam int GW      = $clog2(GAP_CYC + 1);

  seq_state_e             state_q;
  req_op_e                op_q;
  logic [7:0]             addr_q;
  logic [WORD_BITS-1:0]   arg_q;
  logic [WORD_BITS-1:0]   old_q;
  logic                   second_q;
  logic [GW-1:0]          gcnt_q;
  wire_op_e               wop;
  logic [WORD_BITS-1:0]   wword;
  logic                   is_rmw;
  logic                   gap_end;

  assign is_rmw  = (op_q == REQ_SET) || (op_q == REQ_CLEAR);
  assign gap_end = (gcnt_q == GW'(GAP_CYC - 1));

  always_comb begin
    wop = ((op_q == REQ_WRITE) || second_q) ? WIRE_WR_REG : WIRE_RD_REG;
    if (wop == WIRE_RD_REG) begin
      wword = '0;
    end else if (op_q == REQ_WRITE) begin
      wword = arg_q;
    end else begin
      wword = merge_bits(op_q, old_q, arg_q);
    end
  end

  assign tx_frame  = pack_frame(make_header(wop, addr_q), wword);
  assign start     = (state_q == S_LAUNCH);
  assign req_ready = (state_q == S_IDLE);
  assign busy      = (state_q != S_IDLE);
  assign rd_data   = old_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      op_q     <= REQ_READ;
      addr_q   <= '0;
      arg_q    <= '0;
      old_q    <= '0;
      second_q <= 1'b0;
      gcnt_q   <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (req_valid) begin
            op_q     <= req_op_e'(req_op);
            addr_q   <= req_addr;
            arg_q    <= req_wdata;
            second_q <= 1'b0;
            state_q  <= S_LAUNCH;
          end
        end
        S_LAUNCH: begin
          state_q <= S_XFER;
        end
        S_XFER: begin
          if (shift_finish) begin
            if (wop == WIRE_RD_REG) begin
              old_q <= unpack_word(rx_word);
            end
            gcnt_q  <= '0;
            state_q <= S_GAP;
          end
        end
        S_GAP: begin
          if (gap_end) begin
            if (is_rmw && !second_q) begin
              second_q <= 1'b1;
              state_q  <= S_LAUNCH;
            end else begin
              done    <= 1'b1;
              state_q <= S_IDLE;
            end
          end else begin
            gcnt_q <= gcnt_q + GW'(1);
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_reg_engine.sv
module spi_reg_engine
  import spi_reg_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_op,
  input  logic [7:0]  req_addr,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        spi_cs_n,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso
);

  logic                  seq_start;
  logic [FRAME_BITS-1:0] seq_frame;
  logic                  shift_active;
  logic                  shift_tick;
  logic                  shift_rise_evt;
  logic                  shift_finish;
  logic [WORD_BITS-1:0]  shift_rx;

  spi_reg_seq #(.HALF_DIV(HALF_DIV)) seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_op       (req_op),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .shift_finish (shift_finish),
    .rx_word      (shift_rx),
    .req_ready    (req_ready),
    .busy         (busy),
    .done         (done),
    .rd_data      (rd_data),
    .start        (seq_start),
    .tx_frame     (seq_frame)
  );

  spi_reg_clkdiv #(.HALF_DIV(HALF_DIV)) div_i (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (shift_active),
    .tick  (shift_tick)
  );

  spi_reg_shifter #(.FRAME_BITS(FRAME_BITS), .RX_BITS(WORD_BITS)) shf_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (seq_start),
    .tick     (shift_tick),
    .tx_frame (seq_frame),
    .miso     (spi_miso),
    .cs_n     (spi_cs_n),
    .sclk     (spi_sclk),
    .mosi     (spi_mosi),
    .rx_word  (shift_rx),
    .active   (shift_active),
    .rise_evt (shift_rise_evt),
    .finish   (shift_finish)
  );

endmodule

// File: rtl/spi_reg_engine_chk.sv
module spi_reg_engine_chk
  import spi_reg_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic done,
  input logic spi_cs_n,
  input logic spi_sclk,
  input logic spi_mosi,
  input logic seq_start,
  input logic shift_rise_evt,
  input logic shift_finish
);

  localparam int GAP_CYC = 2 * HALF_DIV;
  localparam int GW      = $clog2(GAP_CYC + 1) + 1;
  localparam int RW      = $clog2(FRAME_BITS + 1);

  logic [GW-1:0] hi_cnt;
  logic [RW-1:0] rise_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= GW'(GAP_CYC);
    end else if (!spi_cs_n) begin
      hi_cnt <= '0;
    end else if (hi_cnt < GW'(GAP_CYC)) begin
      hi_cnt <= hi_cnt + GW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_cnt <= '0;
    end else if (seq_start) begin
      rise_cnt <= '0;
    end else if (shift_rise_evt) begin
      rise_cnt <= rise_cnt + RW'(1);
    end
  end

  AST_SCLK_REST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R4

  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R4

  AST_RISES_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    shift_finish |-> (rise_cnt == RW'(FRAME_BITS))); // R5

  AST_CS_RISE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> !spi_sclk); // R5

  AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> spi_cs_n); // R5

  AST_TAKE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10

  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (hi_cnt >= GW'(GAP_CYC))); // R11

  AST_LAUNCH_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> spi_cs_n); // R11

endmodule

bind spi_reg_engine spi_reg_engine_chk #(.HALF_DIV(HALF_DIV)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .busy           (busy),
  .done           (done),
  .spi_cs_n       (spi_cs_n),
  .spi_sclk       (spi_sclk),
  .spi_mosi       (spi_mosi),
  .seq_start      (seq_start),
  .shift_rise_evt (shift_rise_evt),
  .shift_finish   (shift_finish)
);

// File: tb/spi_reg_engine_tb_top.sv
`timescale 1ns/1ps
module spi_reg_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'b00;
  logic [7:0]  req_addr = 8'h00;
  logic [15:0] req_wdata = 16'h0000;
  logic        busy, done;
  logic [15:0] rd_data;
  logic        spi_cs_n, spi_sclk, spi_mosi;
  logic        spi_miso = 1'b0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_reg_engine #(.HALF_DIV(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural serial device: register file indexed by offset bits 7:1.
  logic [15:0] mem [0:127];
  int          xa_addr [$];
  int          xa_wr   [$];
  int          xa_data [$];
  int          q_rd    [$];
  int          q_op    [$];
  int          outstanding = 0;

  int          s_bits = 0;
  logic [31:0] s_in = '0;
  bit          s_valid = 0;
  bit          s_wr = 0;
  int          s_idx = 0;
  logic [15:0] s_exp = '0;

  always @(negedge spi_cs_n) begin
    s_bits = 0;
    s_in   = '0;
  end

  always @(posedge spi_sclk) begin
    if (!spi_cs_n) begin
      s_in = {s_in[30:0], spi_mosi};
      s_bits++;
      if (s_bits == 16) begin
        logic [7:0] b0, b1, ea;
        b0 = s_in[15:8];
        b1 = s_in[7:0];
        if (xa_addr.size() == 0) begin
          check(0, "R9 transaction without a taken request", s_in[15:0], 0);
          s_valid = 0;
        end else begin
          ea      = 8'(xa_addr.pop_front());
          s_wr    = (xa_wr.pop_front() != 0);
          s_exp   = 16'(xa_data.pop_front());
          s_idx   = int'(ea[7:1]);
          s_valid = 1;
          check(b0[7:6] == (s_wr ? 2'b01 : 2'b00), "R1 opcode field", b0[7:6], s_wr);
          check(b0[1:0] == ea[7:6], "R1 offset high bits", b0[1:0], ea[7:6]);
          check(b0[5:2] == (ea[1] ? 4'hC : 4'h3), "R3 lane enables", b0[5:2],
                ea[1] ? 4'hC : 4'h3);
          check(b1 == {ea[5:2], 4'h0}, "R2 second header byte", b1, {ea[5:2], 4'h0});
        end
      end
    end
  end

  always @(negedge spi_sclk) begin
    if (!spi_cs_n && s_valid && !s_wr && s_bits >= 16 && s_bits < 32) begin
      logic [15:0] stream;
      stream   = {mem[s_idx][7:0], mem[s_idx][15:8]};
      spi_miso = stream[15 - (s_bits - 16)];
    end
  end

  always @(posedge spi_cs_n) begin
    if (rst_n) begin
      check(s_bits == 32, "R5 rising edges per transaction", s_bits, 32);
      if (s_valid && s_wr) begin
        logic [15:0] got;
        got = {s_in[7:0], s_in[15:8]};
        check(got == s_exp, "R4 write data byte order", got, s_exp);
        mem[s_idx] = got;
      end
      s_valid  = 0;
      spi_miso = 1'b0;
    end
  end

  // Per-clock reference comparison.
  bit m_busy = 0, m_pend = 0, p_done = 0, p_sclk = 0, p_mosi = 0, p_cs = 1;
  bit seen_frame = 0;
  int evt_cnt = 0, gap_cnt = 0, b2b_seen = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (m_pend) begin
        m_busy = 1;
        m_pend = 0;
      end
      if (done) begin
        check(m_busy, "R10 done without request", done, 0);
        check(!p_done, "R10 done longer than one cycle", p_done, 0);
        m_busy = 0;
        outstanding--;
        if (q_rd.size() > 0) begin
          int e, o;
          e = q_rd.pop_front();
          o = q_op.pop_front();
          if (e >= 0) begin
            if (o == 2)
              check(rd_data == 16'(e), "R7 set returns old value", rd_data, e);
            else if (o == 3)
              check(rd_data == 16'(e), "R8 clear returns old value", rd_data, e);
            else
              check(rd_data == 16'(e), "R6 read data", rd_data, e);
          end
        end
        if (req_valid && req_ready) b2b_seen++;
      end
      check(busy == m_busy, "R10 busy versus model", busy, m_busy);
      check(req_ready == !m_busy, "R9 ready versus model", req_ready, !m_busy);
      if (spi_cs_n) check(!spi_sclk, "R4 sclk rests low", spi_sclk, 0);
      if (spi_sclk && p_sclk)
        check(spi_mosi == p_mosi, "R4 mosi moved while sclk high", spi_mosi, p_mosi);
      evt_cnt++;
      if (p_cs && !spi_cs_n) begin
        if (seen_frame)
          check(gap_cnt >= 2*HALF, "R11 chip select gap", gap_cnt, 2*HALF);
        seen_frame = 1;
        gap_cnt = 0;
        evt_cnt = 0;
      end else if ((!spi_cs_n || !p_cs) && spi_sclk != p_sclk) begin
        check(evt_cnt == HALF, "R11 sclk half period", evt_cnt, HALF);
        evt_cnt = 0;
      end
      if (spi_cs_n) gap_cnt++;
      if (req_valid && req_ready) m_pend = 1;
    end
    p_done = done;
    p_sclk = spi_sclk;
    p_mosi = spi_mosi;
    p_cs   = spi_cs_n;
  end

  task automatic issue(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d);
    int idx;
    @(posedge clk); #1;
    req_valid = 1; req_op = op; req_addr = a; req_wdata = d;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    idx = int'(a[7:1]);
    outstanding++;
    q_op.push_back(int'(op));
    case (op)
      2'b00: begin
        xa_addr.push_back(a); xa_wr.push_back(0); xa_data.push_back(0);
        q_rd.push_back(int'(mem[idx]));
      end
      2'b01: begin
        xa_addr.push_back(a); xa_wr.push_back(1); xa_data.push_back(int'(d));
        q_rd.push_back(-1);
      end
      2'b10: begin
        xa_addr.push_back(a); xa_wr.push_back(0); xa_data.push_back(0);
        xa_addr.push_back(a); xa_wr.push_back(1); xa_data.push_back(int'(mem[idx] | d));
        q_rd.push_back(int'(mem[idx]));
      end
      default: begin
        xa_addr.push_back(a); xa_wr.push_back(0); xa_data.push_back(0);
        xa_addr.push_back(a); xa_wr.push_back(1); xa_data.push_back(int'(mem[idx] & ~d));
        q_rd.push_back(int'(mem[idx]));
      end
    endcase
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic poke_busy(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    req_valid = 1; req_op = op; req_addr = a; req_wdata = d;
    @(negedge clk);
    check(!req_ready, "R9 request while busy not taken", req_ready, 0);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic wait_all();
    while (outstanding != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] keep;
    for (int i = 0; i < 128; i++) mem[i] = 16'hA5C3 ^ 16'(i * 257);
    repeat (3) @(negedge clk);
    check(spi_cs_n == 1'b1, "R12 cs_n in reset", spi_cs_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(spi_cs_n == 1'b1, "R12 cs_n after reset", spi_cs_n, 1);
    check(spi_sclk == 1'b0, "R12 sclk after reset", spi_sclk, 0);
    check(!busy && !done, "R12 busy and done after reset", {busy, done}, 0);
    check(req_ready == 1'b1, "R12 ready after reset", req_ready, 1);

    issue(2'b01, 8'h10, 16'h3A30); wait_all();
    issue(2'b01, 8'h12, 16'h2524); wait_all();
    issue(2'b01, 8'h14, 16'hFE7A); wait_all();
    issue(2'b00, 8'h10, 16'h0); wait_all();
    issue(2'b00, 8'h12, 16'h0); wait_all();
    issue(2'b00, 8'h14, 16'h0); wait_all();
    issue(2'b00, 8'hC0, 16'h0); wait_all();
    issue(2'b00, 8'hFE, 16'h0); wait_all();
    issue(2'b00, 8'h02, 16'h0); wait_all();

    issue(2'b10, 8'h74, 16'h0001); wait_all();
    issue(2'b11, 8'h74, 16'h8000); wait_all();
    issue(2'b10, 8'h76, 16'h0000); wait_all();
    issue(2'b11, 8'h70, 16'hFFFF); wait_all();
    issue(2'b00, 8'h74, 16'h0); wait_all();
    issue(2'b00, 8'h70, 16'h0); wait_all();
    check(mem[8'h70 >> 1] == 16'h0000, "R8 clear all bits", mem[8'h70 >> 1], 0);

    // Ignored request during a transfer.
    keep = mem[8'h92 >> 1];
    issue(2'b01, 8'h90, 16'h1111);
    repeat (20) @(negedge clk);
    poke_busy(2'b01, 8'h92, 16'hBEEF);
    wait_all();
    issue(2'b00, 8'h92, 16'h0); wait_all();
    check(mem[8'h92 >> 1] == keep, "R9 ignored write left register", mem[8'h92 >> 1], keep);

    // Back-to-back: second request held until the done cycle.
    issue(2'b10, 8'h9C, 16'h0101);
    issue(2'b01, 8'h9E, 16'hC0DE);
    issue(2'b00, 8'h9E, 16'h0);
    wait_all();
    check(b2b_seen >= 2, "R9 request taken in done cycle", b2b_seen, 2);
    check(xa_addr.size() == 0, "R6 all transactions seen", xa_addr.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule